// File: doc/BRIEF.md
# Parallel Ramp-Compare Conversion Controller

This block sequences a ramp-type analog-to-digital conversion of many stored samples at once. On a start strobe it first holds the shared voltage ramp in reset for a fixed number of cycles. It then releases the ramp and runs one fast count for the duration of the ramp. Every cell has its own comparator. The comparator rises once the ramp passes the voltage that the cell stores, and the cell then captures the count of that moment. The count is kept in Gray code, so that a capture taken while the count is changing is off by at most one.

When the count reaches a programmed limit the ramp stops. All captured Gray values are then turned into binary in a single cycle, and a one-cycle done strobe marks the moment the codes become valid. A cell whose comparator never fired reports full scale. The ramp generator and the comparators are analog and sit outside this block. Shifting the codes out to a readout path is also left to other logic.

Top module: `wilk_digitizer_ctrl`

## Requirements
- R1: After reset, `done_o`, `ramp_en_o` and `ramp_rst_o` are low and every code in `codes_o` is zero.
- R2: A `start_i` pulse in idle raises `ramp_rst_o` for exactly HOLD_CYCLES cycles. `ramp_en_o` rises in the cycle after that, and the two controls are never high together.
- R3: `ramp_en_o` stays high for (limit + 1) cycles, one for each count from 0 to the limit. `done_o` is then high for exactly one cycle, the second cycle after the last ramp cycle. From that cycle on, `codes_o` holds until the next conversion finishes.
- R4: The running count is Gray coded, so it changes exactly one bit per ramp cycle. Each reported code is the plain binary value of the captured count, and this holds across the full 12-bit range.
- R5: A comparator that is first seen high at the clock edge ending ramp cycle j (ramp cycles count from 0) reports code j+2. The two extra counts come from a two-flop synchronizer followed by edge detection.
- R6: Only the first rising comparator edge in a conversion captures a code. Later edges in the same conversion change nothing.
- R7: A cell whose comparator never rises during the ramp reports 4095 (all ones).
- R8: A `start_i` pulse while a conversion is in progress is ignored. The ramp length does not change, and the block returns to idle after `done_o` without starting a new ramp reset.
- R9: The limit on `max_count_i` is taken at the accepted start. A change to that input during the ramp has no effect on the ramp length.
- R10: Every cell captures independently and in parallel against the same count. Cell k appears at bits [k*12 +: 12] of `codes_o`.
- R11: Rising edges that are detected outside the ramp cycles capture nothing. This covers a comparator that is already high before the ramp starts, and an edge that reaches the detector after the last ramp cycle. Either cell reports 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count and control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start strobe, accepted only in idle |
| cmp_i | input | 64 | Per-cell comparator outputs, asynchronous |
| max_count_i | input | 12 | Last count value of the ramp |
| codes_o | output | 768 | Binary conversion codes, cell k at [k*12 +: 12] |
| done_o | output | 1 | One-cycle strobe: codes are valid |
| ramp_en_o | output | 1 | Ramp running (the count advances) |
| ramp_rst_o | output | 1 | Hold the ramp at its start level |

## Verification
The bench keeps the defaults of 64 cells and 12-bit codes, so every cell position and every code bit is exercised. It lowers the reset hold to 3 cycles, so the hold length it measures comes from the parameter and not from a coincidence with the default. Short limits put the captures right next to the end of the ramp, including edges that arrive just late. One full-scale ramp to 4095 drives the count through its high-order Gray carries and up to the top code.

// File: rtl/wilk_pkg.sv
package wilk_pkg;

    // Phases of one conversion
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP_RST,
        ST_RAMPING,
        ST_CONVERT,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/wk_sequencer.sv
module wk_sequencer
    import wilk_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ramp_last_i,
    output logic capture_o,
    output logic ramp_rst_o,
    output logic ramp_en_o,
    output logic convert_o,
    output logic done_o
);
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [HOLD_W-1:0] hold;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_RAMP_RST;
                    r_d.hold  = '0;
                end
            end
            ST_RAMP_RST: begin
                if (r_q.hold == HOLD_W'(HOLD_CYCLES - 1)) begin
                    r_d.state = ST_RAMPING;
                end else begin
                    r_d.hold = r_q.hold + 1'b1;
                end
            end
            ST_RAMPING: begin
                if (ramp_last_i) begin
                    r_d.state = ST_CONVERT;
                end
            end
            ST_CONVERT: r_d.state = ST_DONE;
            ST_DONE:    r_d.state = ST_IDLE;
            default:    r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.hold  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign capture_o  = (r_q.state == ST_IDLE) && start_i;
    assign ramp_rst_o = (r_q.state == ST_RAMP_RST);
    assign ramp_en_o  = (r_q.state == ST_RAMPING);
    assign convert_o  = (r_q.state == ST_CONVERT);
    assign done_o     = (r_q.state == ST_DONE);

    // R2: ramp reset and ramp run never overlap
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_rst_o && ramp_en_o));

    // R2: the ramp is always released from a reset phase
    a_r2_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_en_o) |-> $past(ramp_rst_o));

    // R3: done lasts exactly one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a start during the ramp neither restarts nor aborts it
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en_o && start_i) |=> (ramp_en_o || convert_o));

endmodule

// File: rtl/wk_gray_counter.sv
module wk_gray_counter #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] max_i,
    input  logic              run_i,
    output logic [CODE_W-1:0] gray_o,
    output logic              last_o
);
    typedef struct packed {
        logic [CODE_W-1:0] bin;
        logic [CODE_W-1:0] gray;
        logic [CODE_W-1:0] limit;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.limit = max_i;
        end
        r_d.bin  = run_i ? (r_q.bin + 1'b1) : '0;
        r_d.gray = r_d.bin ^ (r_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gray_o = r_q.gray;
    assign last_o = run_i && (r_q.bin == r_q.limit);

    // R4: the shared count moves by a single bit per ramp cycle
    a_r4_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i)) |-> ($countones(gray_o ^ $past(gray_o)) == 1));

    // R9: the limit is frozen while the ramp runs
    a_r9_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i)) |-> $stable(r_q.limit));

endmodule

// File: rtl/wk_cell_latch.sv
module wk_cell_latch #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_i,
    input  logic              clear_i,
    input  logic              arm_i,
    input  logic              convert_i,
    input  logic [CODE_W-1:0] gray_i,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic              sync1;
        logic              sync2;
        logic              prev;
        logic              hit;
        logic [CODE_W-1:0] held;
        logic [CODE_W-1:0] code;
    } cell_regs_t;

    cell_regs_t        r_d, r_q;
    logic [CODE_W-1:0] held_bin;
    logic              edge_seen;

    // Gray to binary: each bit is the xor of itself and all bits above it
    always_comb begin
        held_bin[CODE_W-1] = r_q.held[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            held_bin[i] = held_bin[i+1] ^ r_q.held[i];
        end
    end

    assign edge_seen = r_q.sync2 && !r_q.prev;

    always_comb begin
        r_d       = r_q;
        r_d.sync1 = cmp_i;
        r_d.sync2 = r_q.sync1;
        r_d.prev  = r_q.sync2;
        if (clear_i) begin
            r_d.hit = 1'b0;
        end else if (arm_i && edge_seen && !r_q.hit) begin
            r_d.hit  = 1'b1;
            r_d.held = gray_i;
        end
        if (convert_i) begin
            r_d.code = r_q.hit ? held_bin : {CODE_W{1'b1}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o = r_q.code;

    // R6: once captured, the value survives every later edge
    a_r6_first_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hit && !clear_i) |=> (r_q.hit && $stable(r_q.held)));

    // R7: a cell without a capture converts to full scale
    a_r7_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (convert_i && !r_q.hit) |=> (code_o == {CODE_W{1'b1}}));

    // R11: nothing is captured outside the ramp
    a_r11_no_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !r_q.hit) |=> !r_q.hit);

endmodule

// File: rtl/wilk_digitizer_ctrl.sv
module wilk_digitizer_ctrl #(
    parameter int NUM_CELLS   = 64,
    parameter int CODE_W      = 12,
    parameter int HOLD_CYCLES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [NUM_CELLS-1:0]        cmp_i,
    input  logic [CODE_W-1:0]           max_count_i,
    output logic [NUM_CELLS*CODE_W-1:0] codes_o,
    output logic                        done_o,
    output logic                        ramp_en_o,
    output logic                        ramp_rst_o
);
    localparam int CODES_W = NUM_CELLS * CODE_W;

    logic              capture;
    logic              ramp_last;
    logic              convert;
    logic              ramp_en;
    logic              ramp_rst;
    logic [CODE_W-1:0] gray;

    wk_sequencer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ramp_last_i(ramp_last),
        .capture_o  (capture),
        .ramp_rst_o (ramp_rst),
        .ramp_en_o  (ramp_en),
        .convert_o  (convert),
        .done_o     (done_o)
    );

    wk_gray_counter #(
        .CODE_W(CODE_W)
    ) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(capture),
        .max_i (max_count_i),
        .run_i (ramp_en),
        .gray_o(gray),
        .last_o(ramp_last)
    );

    for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
        wk_cell_latch #(
            .CODE_W(CODE_W)
        ) i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmp_i    (cmp_i[k]),
            .clear_i  (ramp_rst),
            .arm_i    (ramp_en),
            .convert_i(convert),
            .gray_i   (gray),
            .code_o   (codes_o[k*CODE_W +: CODE_W])
        );
    end

    assign ramp_en_o  = ramp_en;
    assign ramp_rst_o = ramp_rst;

    // R3: results change only on the cycle after conversion
    a_r3_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !convert |=> $stable(codes_o[CODES_W-1:0]));

endmodule

// File: tb/test_wilk_digitizer_ctrl.sv
`timescale 1ns/1ps
module test_wilk_digitizer_ctrl;
    localparam int N      = 64;
    localparam int W      = 12;
    localparam int HOLD   = 3;
    localparam int FULL   = 4095;
    localparam int CLK_NS = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   cmp = '0;
    logic [W-1:0]   maxc = '0;
    logic [N*W-1:0] codes;
    logic           done;
    logic           ramp_en;
    logic           ramp_rst;

    int    checks = 0;
    int    errors = 0;
    int    fire_at[N];
    int    drop_at[N];
    int    refire_at[N];
    bit    pre_high[N];
    string tag[N];

    always #(CLK_NS / 2) clk = ~clk;

    wilk_digitizer_ctrl #(
        .NUM_CELLS  (N),
        .CODE_W     (W),
        .HOLD_CYCLES(HOLD)
    ) i_wilk_digitizer_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cmp_i      (cmp),
        .max_count_i(maxc),
        .codes_o    (codes),
        .done_o     (done),
        .ramp_en_o  (ramp_en),
        .ramp_rst_o (ramp_rst)
    );

    task automatic check_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic clear_plan();
        for (int c = 0; c < N; c++) begin
            fire_at[c]   = -1;
            drop_at[c]   = -1;
            refire_at[c] = -1;
            pre_high[c]  = 1'b0;
            tag[c]       = "R7";
        end
    endtask

    function automatic int expect_code(int c, int m);
        if (fire_at[c] >= 0 && fire_at[c] + 2 <= m) return fire_at[c] + 2;
        return FULL;
    endfunction

    // One full conversion with limit m; optional stray start and limit change
    task automatic run_conv(int m, bit stray, int new_max, string len_req);
        int hold_n;
        int j;
        int c0;
        maxc = W'(m);
        for (int c = 0; c < N; c++) if (pre_high[c]) cmp[c] = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hold_n = 0;
        while (!ramp_en) begin
            if (ramp_rst) hold_n++;
            @(negedge clk);
        end
        check_int("R2", "ramp reset length", hold_n, HOLD);
        check_int("R2", "reset low while ramping", int'(ramp_rst), 0);
        j = 0;
        while (ramp_en) begin
            for (int c = 0; c < N; c++) begin
                if (fire_at[c] == j)   cmp[c] = 1'b1;
                if (drop_at[c] == j)   cmp[c] = 1'b0;
                if (refire_at[c] == j) cmp[c] = 1'b1;
            end
            start = (stray && j == 2);
            if (j == 1 && new_max >= 0) maxc = W'(new_max);
            j++;
            @(negedge clk);
        end
        start = 1'b0;
        check_int(len_req, "ramp length", j, m + 1);
        check_int("R3", "done low in convert cycle", int'(done), 0);
        @(negedge clk);
        check_int("R3", "done high", int'(done), 1);
        for (int c = 0; c < N; c++) begin
            check_int(tag[c], $sformatf("code cell %0d", c),
                      int'(codes[c*W +: W]), expect_code(c, m));
        end
        c0 = int'(codes[0 +: W]);
        cmp = '0;
        @(negedge clk);
        check_int("R3", "done single cycle", int'(done), 0);
        check_int(stray ? "R8" : "R3", "idle after done", int'(ramp_rst || ramp_en), 0);
        check_int("R3", "code held after done", int'(codes[0 +: W]), c0);
        repeat (2) @(negedge clk);
        check_int(stray ? "R8" : "R3", "no restart", int'(ramp_rst || ramp_en), 0);
    endtask

    task automatic test_reset();
        int nz;
        nz = 0;
        for (int c = 0; c < N; c++) if (codes[c*W +: W] != '0) nz++;
        check_int("R1", "done after reset", int'(done), 0);
        check_int("R1", "ramp_en after reset", int'(ramp_en), 0);
        check_int("R1", "ramp_rst after reset", int'(ramp_rst), 0);
        check_int("R1", "nonzero codes after reset", nz, 0);
    endtask

    // R10: every cell at its own cycle
    task automatic test_parallel();
        clear_plan();
        for (int c = 0; c < N; c++) begin
            fire_at[c] = (c * 7) % 37;
            tag[c]     = "R10";
        end
        run_conv(40, 1'b0, -1, "R3");
    endtask

    // R5, R7, R11 around the end of a short ramp
    task automatic test_boundary();
        clear_plan();
        fire_at[0] = 18; tag[0] = "R5";
        fire_at[1] = 19; tag[1] = "R11";
        fire_at[2] = 20; tag[2] = "R11";
        pre_high[4] = 1'b1; tag[4] = "R11";
        fire_at[5] = 0;  tag[5] = "R5";
        run_conv(20, 1'b0, -1, "R3");
        clear_plan();
        fire_at[9] = 0; tag[9] = "R5";
        run_conv(0, 1'b0, -1, "R3");
    endtask

    // R6 re-fires and pulses, R8 stray start, R9 limit change mid-ramp
    task automatic test_refire_stray();
        clear_plan();
        for (int c = 0; c < 8; c++) begin
            fire_at[c] = 3; drop_at[c] = 6; refire_at[c] = 10; tag[c] = "R6";
        end
        for (int c = 8; c < 16; c++) begin
            fire_at[c] = 12; drop_at[c] = 13; refire_at[c] = 20; tag[c] = "R6";
        end
        run_conv(30, 1'b1, 5, "R9");
    endtask

    // R4: full 12-bit ramp through all Gray carries
    task automatic test_full_scale();
        clear_plan();
        for (int c = 0; c < N - 1; c++) begin
            fire_at[c] = c * 64 + 1 + (c % 5);
            tag[c]     = "R4";
        end
        fire_at[N-1] = 4093; tag[N-1] = "R4";
        run_conv(FULL, 1'b0, -1, "R4");
    endtask

    initial begin
        clear_plan();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_parallel();
        test_boundary();
        test_refire_stray();
        test_full_scale();
        summary();
    end

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule